// File: doc/BRIEF.md
# Reference-Counted Pad Isolation Sequencer

This block controls the isolation of an I/O pad domain that several independent users share. Each user sends a single-cycle power-up or power-down request. The block keeps a usage count. Only the first power-up and the last power-down touch the three isolation outputs. The first power-up releases them in a fixed order, with a programmable gap of `GAP_CYC` clock cycles between steps; this gap stands for a fixed delay in microseconds. The last power-down asserts them again in the reverse order, with the same gaps.

A request can also carry a PHY flag. With the flag, a power-up becomes a prepare: once the domain is powered, the shared PHY reset is released. With the flag, a power-down becomes an unprepare: the PHY reset is asserted one cycle before the power-down takes effect. A force-off pulse asserts the PHY reset and drains the count one step per cycle until the domain is fully isolated again.

A request that arrives while a sequence is running is held in a one-deep pending slot. It runs as soon as the block goes idle. A request that cannot be honoured produces a one-cycle error pulse and has no other effect.

Top module: `pad_iso_seq`

## Requirements
- R1: After reset, `core_off_o`, `iso_pre_o`, `iso_o` and `phy_rst_o` are all 1, `use_cnt_o` is 0, and `busy_o` and `err_o` are 0.
- R2: A power-up accepted at count 0 sets the count to 1 and clears `iso_o` on the accepting edge. It clears `iso_pre_o` `GAP_CYC` cycles later, and `core_off_o` `GAP_CYC` cycles after that.
- R3: A power-up accepted at a count that is neither 0 nor the maximum increments the count and leaves every output unchanged.
- R4: A power-down accepted at count 1 sets the count to 0 and sets `core_off_o` on its first step. It sets `iso_pre_o` `GAP_CYC` cycles later, and `iso_o` `GAP_CYC` cycles after that.
- R5: A power-down accepted at a count above 1 decrements the count and leaves every output unchanged.
- R6: A power-down at count 0 pulses `err_o` for one cycle and changes neither the count nor any other output.
- R7: A prepare (`phy_op_i`=1 with `up_req_i`) clears `phy_rst_o` on the edge that clears `core_off_o`, or on the accepting edge if the count was already above 0. An unprepare (`phy_op_i`=1 with `dn_req_i`) sets `phy_rst_o` on the accepting edge, and its power-down step follows one cycle later.
- R8: A `force_off_i` pulse sets `phy_rst_o` on the next edge. The count then drops by one per cycle. The drop from 1 to 0 runs the R4 sequence, and `busy_o` stays 1 until the count is 0 and all isolation outputs are 1.
- R9: `busy_o` is 1 from the edge after a sequence starts until the edge that completes its last step.
- R10: A valid request that arrives while the block is busy is stored and runs after the current sequence. A request that arrives while the slot is already full is dropped and pulses `err_o`.
- R11: The count is `CNT_W` bits wide and saturates. A power-up at the maximum value pulses `err_o` and leaves the count and outputs unchanged.
- R12: `up_req_i` and `dn_req_i` high in the same cycle pulse `err_o`, and neither request is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Power-up request pulse |
| dn_req_i | input | 1 | Power-down request pulse |
| phy_op_i | input | 1 | Marks the request as prepare or unprepare |
| force_off_i | input | 1 | Force-off pulse |
| core_off_o | output | 1 | Core supply down (1 = down) |
| iso_pre_o | output | 1 | Early isolation hold (1 = held) |
| iso_o | output | 1 | Main isolation hold (1 = held) |
| phy_rst_o | output | 1 | PHY reset (1 = in reset) |
| busy_o | output | 1 | Sequence or force drain in progress |
| err_o | output | 1 | One-cycle refused-request pulse |
| use_cnt_o | output | CNT_W | Current usage count |

## Verification
The bench targets step ordering and the exact edge of each step. A design that swaps the order would release the core supply while a hold is still on, or drop the holds before the supply is down. Refused requests are checked at count 0, at saturation, with both request pulses together, and with the pending slot full. In each of these cases a faulty design would change the count or the outputs instead of only pulsing the error. The force drain from 3 and from 255 checks that a design cannot stop early or skip the final isolation steps. The pending-slot case checks that a request arriving mid-sequence is not lost.

// File: rtl/pad_iso_seq_pkg.sv
package pad_iso_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PHY,
    ST_UP1,
    ST_UP2,
    ST_DN1,
    ST_DN2
  } seq_st_e;

  typedef struct packed {
    logic up;   // 1 = power-up, 0 = power-down
    logic phy;  // prepare / unprepare
  } seq_cmd_t;
endpackage

// File: rtl/pad_iso_gap_timer.sv
module pad_iso_gap_timer #(
  parameter int unsigned GAP_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned TW = $clog2(GAP_CYC + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= TW'(GAP_CYC - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pad_iso_req_slot.sv
module pad_iso_req_slot
  import pad_iso_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  logic     pop_i,
  input  seq_cmd_t cmd_i,
  output logic     valid_o,
  output seq_cmd_t cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cmd_o   <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      cmd_o   <= cmd_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pad_iso_seq.sv
module pad_iso_seq
  import pad_iso_seq_pkg::*;
#(
  parameter int unsigned GAP_CYC = 100,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_req_i,
  input  logic             dn_req_i,
  input  logic             phy_op_i,
  input  logic             force_off_i,
  output logic             core_off_o,
  output logic             iso_pre_o,
  output logic             iso_o,
  output logic             phy_rst_o,
  output logic             busy_o,
  output logic             err_o,
  output logic [CNT_W-1:0] use_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  seq_st_e    st_q;
  logic [CNT_W-1:0] cnt_q;
  logic       force_q, op_phy_q;
  logic       gap_done, gap_load;
  logic       pend_v;
  seq_cmd_t   pend_cmd, new_cmd, take;
  logic       new_v, both, idle, can_run, run_pend, run_new, run;
  logic       push, drop, refuse, go;
  logic       start_up, inc, down_step, start_dn, dec;

  assign new_v   = up_req_i ^ dn_req_i;
  assign both    = up_req_i & dn_req_i;
  assign new_cmd = '{up: up_req_i, phy: phy_op_i};
  assign idle    = (st_q == ST_IDLE);
  assign can_run = idle && !force_q && !force_off_i;
  assign run_pend = can_run && pend_v;
  assign run_new  = can_run && !pend_v && new_v;
  assign run      = run_pend || run_new;
  assign take     = run_pend ? pend_cmd : new_cmd;
  assign push     = new_v && !run_new && (!pend_v || run_pend);
  assign drop     = new_v && !run_new && pend_v && !run_pend;
  assign refuse   = run && (take.up ? (cnt_q == CNT_MAX) : (cnt_q == '0));
  assign go       = run && !refuse;

  always_comb begin
    start_up  = go && take.up && (cnt_q == '0);
    inc       = go && take.up && (cnt_q != '0);
    down_step = (st_q == ST_PHY)
             || (go && !take.up && !take.phy)
             || (idle && force_q && (cnt_q != '0));
    start_dn  = down_step && (cnt_q == CNT_W'(1));
    dec       = down_step && (cnt_q != CNT_W'(1));
    gap_load  = start_up || start_dn
             || (st_q == ST_UP1 && gap_done) || (st_q == ST_DN1 && gap_done);
  end

  pad_iso_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .done_o (gap_done)
  );

  pad_iso_req_slot u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (run_pend),
    .cmd_i   (new_cmd),
    .valid_o (pend_v),
    .cmd_o   (pend_cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      force_q    <= 1'b0;
      op_phy_q   <= 1'b0;
      err_o      <= 1'b0;
      core_off_o <= 1'b1;
      iso_pre_o  <= 1'b1;
      iso_o      <= 1'b1;
      phy_rst_o  <= 1'b1;
    end else begin
      err_o <= both || drop || refuse;
      if (start_up) begin
        cnt_q    <= CNT_W'(1);
        iso_o    <= 1'b0;
        op_phy_q <= take.phy;
        st_q     <= ST_UP1;
      end
      if (inc) begin
        cnt_q <= cnt_q + 1'b1;
        if (take.phy) phy_rst_o <= 1'b0;
      end
      if (go && !take.up && take.phy) begin
        phy_rst_o <= 1'b1;
        st_q      <= ST_PHY;
      end
      if (dec) begin
        cnt_q <= cnt_q - 1'b1;
        st_q  <= ST_IDLE;
      end
      if (start_dn) begin
        cnt_q      <= '0;
        core_off_o <= 1'b1;
        st_q       <= ST_DN1;
      end
      if (idle && force_q && cnt_q == '0) force_q <= 1'b0;
      if (gap_done) begin
        unique case (st_q)
          ST_UP1: begin iso_pre_o <= 1'b0; st_q <= ST_UP2; end
          ST_UP2: begin
            core_off_o <= 1'b0;
            if (op_phy_q) phy_rst_o <= 1'b0;
            st_q <= ST_IDLE;
          end
          ST_DN1: begin iso_pre_o <= 1'b1; st_q <= ST_DN2; end
          ST_DN2: begin iso_o <= 1'b1; st_q <= ST_IDLE; end
          default: ;
        endcase
      end
      // force wins over any release on the same edge
      if (force_off_i) begin
        force_q   <= 1'b1;
        phy_rst_o <= 1'b1;
      end
    end
  end

  assign busy_o    = !idle || force_q;
  assign use_cnt_o = cnt_q;
endmodule

// File: rtl/pad_iso_seq_chk.sv
module pad_iso_seq_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             core_off_o,
  input logic             iso_pre_o,
  input logic             iso_o,
  input logic             phy_rst_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] use_cnt_o
);
  AST_UP_PRE_AFTER_ISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_pre_o) |-> !iso_o); // R2
  AST_UP_CORE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_off_o) |-> (!iso_pre_o && !iso_o)); // R2
  AST_DN_PRE_AFTER_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_pre_o) |-> core_off_o); // R4
  AST_DN_ISO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> (core_off_o && iso_pre_o)); // R4
  AST_PARTIAL_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((core_off_o && iso_pre_o && iso_o) || !(core_off_o || iso_pre_o || iso_o)) |-> busy_o); // R9
  AST_ZERO_IDLE_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_cnt_o == '0 && !busy_o) |-> (core_off_o && iso_pre_o && iso_o)); // R6
  AST_CNT_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_cnt_o != $past(use_cnt_o)) |->
      (CNT_W'(use_cnt_o - $past(use_cnt_o)) == CNT_W'(1) ||
       CNT_W'($past(use_cnt_o) - use_cnt_o) == CNT_W'(1))); // R11
  AST_PHY_ONLY_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_rst_o |-> !core_off_o); // R7
  AST_POWERED_HAS_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_off_o |-> (use_cnt_o != '0)); // R8
endmodule

bind pad_iso_seq pad_iso_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .core_off_o (core_off_o),
  .iso_pre_o  (iso_pre_o),
  .iso_o      (iso_o),
  .phy_rst_o  (phy_rst_o),
  .busy_o     (busy_o),
  .use_cnt_o  (use_cnt_o)
);

// File: tb/tb_pad_iso_seq.sv
module tb_pad_iso_seq;
  localparam int G = 100;
  localparam int CW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic up_req_i = 0, dn_req_i = 0, phy_op_i = 0, force_off_i = 0;
  logic core_off_o, iso_pre_o, iso_o, phy_rst_o, busy_o, err_o;
  logic [CW-1:0] use_cnt_o;

  int cyc = 0, nchk = 0, nfail = 0, acc = 0;
  bit mon_en = 0, fin = 0;
  int q_cyc[$];
  logic [3:0] q_vec[$];
  logic [3:0] prev = 4'b1111;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pad_iso_seq #(.GAP_CYC(G), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .up_req_i(up_req_i), .dn_req_i(dn_req_i),
    .phy_op_i(phy_op_i), .force_off_i(force_off_i), .core_off_o(core_off_o),
    .iso_pre_o(iso_pre_o), .iso_o(iso_o), .phy_rst_o(phy_rst_o),
    .busy_o(busy_o), .err_o(err_o), .use_cnt_o(use_cnt_o));

  wire [3:0] vec = {core_off_o, iso_pre_o, iso_o, phy_rst_o};

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_at(int c, logic [3:0] v);
    q_cyc.push_back(c);
    q_vec.push_back(v);
  endtask

  // caller is at a negedge; request is taken on the next posedge (cyc+1)
  task automatic fire(logic u, logic d, logic p, logic f);
    up_req_i = u; dn_req_i = d; phy_op_i = p; force_off_i = f;
    @(negedge clk);
    up_req_i = 0; dn_req_i = 0; phy_op_i = 0; force_off_i = 0;
  endtask

  // monitor: every output change must match the next scoreboard item
  always @(negedge clk) if (mon_en) begin
    if (vec !== prev) begin
      nchk++;
      if (q_vec.size() == 0) begin
        nfail++;
        $display("FAIL R3/R5 unexpected change: got %b at %0d expected none", vec, cyc);
      end else begin
        automatic int ec = q_cyc.pop_front();
        automatic logic [3:0] ev = q_vec.pop_front();
        if (vec !== ev || cyc != ec) begin
          nfail++;
          $display("FAIL R2/R4/R7/R8 step: got %b at %0d expected %b at %0d", vec, cyc, ev, ec);
        end
      end
    end
    prev = vec;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    mon_en = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 vec", vec, 4'b1111);
    chk("R1 cnt", use_cnt_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 err", err_o, 0);

    // R2/R7 prepare from zero
    acc = cyc + 1;
    expect_at(acc, 4'b1101); expect_at(acc + G, 4'b1001); expect_at(acc + 2*G, 4'b0000);
    fire(1, 0, 1, 0);
    chk("R9 busy during up", busy_o, 1);
    chk("R2 cnt", use_cnt_o, 1);
    repeat (2*G + 2) @(negedge clk);
    chk("R9 busy after up", busy_o, 0);

    // R3 increment
    fire(1, 0, 0, 0);
    chk("R3 cnt", use_cnt_o, 2);
    chk("R3 busy", busy_o, 0);
    // R5 decrement
    fire(0, 1, 0, 0);
    chk("R5 cnt", use_cnt_o, 1);

    // R7/R4 unprepare at count 1
    acc = cyc + 1;
    expect_at(acc, 4'b0001); expect_at(acc + 1, 4'b1001);
    expect_at(acc + 1 + G, 4'b1101); expect_at(acc + 1 + 2*G, 4'b1111);
    fire(0, 1, 1, 0);
    repeat (2*G + 3) @(negedge clk);
    chk("R4 cnt", use_cnt_o, 0);

    // R6 power-down at zero
    fire(0, 1, 0, 0);
    chk("R6 err", err_o, 1);
    chk("R6 cnt", use_cnt_o, 0);
    @(negedge clk);
    chk("R6 err pulse ends", err_o, 0);

    // R12 both requests
    fire(1, 1, 0, 0);
    chk("R12 err", err_o, 1);
    chk("R12 cnt", use_cnt_o, 0);
    @(negedge clk);

    // R10 pending slot and overflow
    acc = cyc + 1;
    expect_at(acc, 4'b1101); expect_at(acc + G, 4'b1001); expect_at(acc + 2*G, 4'b0001);
    fire(1, 0, 0, 0);
    fire(1, 0, 0, 0);
    fire(0, 1, 0, 0);
    chk("R10 overflow err", err_o, 1);
    repeat (2*G + 5) @(negedge clk);
    chk("R10 queued up ran", use_cnt_o, 2);
    chk("R10 busy", busy_o, 0);

    // R7 prepare at nonzero count
    acc = cyc + 1;
    expect_at(acc, 4'b0000);
    fire(1, 0, 1, 0);
    chk("R7 cnt", use_cnt_o, 3);

    // R8 force drain from 3
    acc = cyc + 1;
    expect_at(acc, 4'b0001); expect_at(acc + 3, 4'b1001);
    expect_at(acc + 3 + G, 4'b1101); expect_at(acc + 3 + 2*G, 4'b1111);
    fire(0, 0, 0, 1);
    @(negedge clk);
    chk("R8 busy", busy_o, 1);
    repeat (2*G + 4) @(negedge clk);
    chk("R8 cnt", use_cnt_o, 0);
    chk("R8 busy end", busy_o, 0);

    // R11 saturation
    acc = cyc + 1;
    expect_at(acc, 4'b1101); expect_at(acc + G, 4'b1001); expect_at(acc + 2*G, 4'b0001);
    fire(1, 0, 0, 0);
    repeat (2*G + 2) @(negedge clk);
    for (int k = 0; k < 254; k++) fire(1, 0, 0, 0);
    chk("R11 max", use_cnt_o, 255);
    fire(1, 0, 0, 0);
    chk("R11 err", err_o, 1);
    chk("R11 held", use_cnt_o, 255);

    // R8 force drain from max
    acc = cyc + 1;
    expect_at(acc + 255, 4'b1001); expect_at(acc + 255 + G, 4'b1101);
    expect_at(acc + 255 + 2*G, 4'b1111);
    fire(0, 0, 0, 1);
    repeat (255 + 2*G + 4) @(negedge clk);
    chk("R8 drained", use_cnt_o, 0);
    chk("R8 all steps seen", q_vec.size(), 0);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule